// File: doc/BRIEF.md
# Phased Crosspoint Command Driver

This block converts a two-bit switch operation, a row address and a column address into the control signals of a crosspoint switch matrix: chip select, strobe, data and a clear-all pulse. Each operation takes one pass through a four-phase cycle. The operation and its addresses are captured when the cycle returns to phase 0. They stay on the outputs for the whole cycle, and the cell-clocking signals are asserted only in phase 1. This gives the addresses time to settle before any cell is clocked.

The phase counter advances on enable ticks. A 3-bit rate code picks the source of these ticks: one of seven taps of a free-running divider, or a synchronised, debounced single-step button. The same command goes to two matrices at once, an internal one and an external one, through separate control port sets. A select input chooses which matrix's column outputs are forwarded. That select is sampled only at phase-0 entry, so it can be changed freely between instructions.

Top module: `swcmd_phaser`

## Requirements
- R1: Operation code 01 (set) drives data to 1 and raises chip select and strobe during phase 1, with clear-all low.
- R2: Operation code 10 (clear) drives data to 0 and raises chip select and strobe during phase 1, with clear-all low.
- R3: Operation code 11 (clear-all) raises only the clear-all signal during phase 1; chip select and strobe stay low.
- R4: Operation code 00 (no-operation) asserts none of chip select, strobe or clear-all in any phase.
- R5: Chip select, strobe and clear-all are never high outside phase 1.
- R6: The operation, row address and column address are captured on the tick that moves the phase from 3 to 0. Data and addresses then hold for all four phases, even if the inputs change.
- R7: The phase steps 0, 1, 2, 3, 0 and moves by exactly one step per enable tick, so one operation spans four ticks.
- R8: Rate code k from 1 to 7 produces one tick every 2^(STEP*(7-k)+1) clock cycles. Code 7 therefore ticks every 2 cycles.
- R9: Rate code 0 advances the phase exactly once per button press. The press must stay stable for DEB_CYC cycles after synchronisation. Shorter pulses, and a button held down, cause no further steps.
- R10: The internal and external control port sets carry the same command in every cycle, whichever matrix is selected.
- R11: The column output forwards the internal columns when the registered select is 0 and the external columns when it is 1. The select input is sampled only at phase-0 entry.
- R12: After reset the phase is 0, the captured operation is no-operation, all control strobes are low and the internal matrix is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Tick source: 0 single-step, 1..7 divider taps, slow to fast |
| step_btn | input | 1 | Asynchronous single-step button |
| op_code | input | 2 | Switch operation: 00 nop, 01 set, 10 clear, 11 clear-all |
| row_addr | input | ROW_AW | Target row |
| col_addr | input | COL_AW | Target column |
| use_ext | input | 1 | Request the external matrix as the column source |
| int_cols | input | COLS | Column outputs of the internal matrix |
| ext_cols | input | COLS | Column outputs of the external matrix |
| phase | output | 2 | Current phase of the four-phase cycle |
| mtx_row | output | ROW_AW | Captured row address, shared by both matrices |
| mtx_col | output | COL_AW | Captured column address, shared by both matrices |
| int_cs | output | 1 | Internal matrix chip select |
| int_strobe | output | 1 | Internal matrix strobe |
| int_data | output | 1 | Internal matrix data |
| int_clr | output | 1 | Internal matrix clear-all |
| ext_cs | output | 1 | External matrix chip select |
| ext_strobe | output | 1 | External matrix strobe |
| ext_data | output | 1 | External matrix data |
| ext_clr | output | 1 | External matrix clear-all |
| col_out | output | COLS | Column outputs of the selected matrix |

## Verification
The bench builds the block with STEP=1 and DEB_CYC=4, keeping 16 rows and columns. With STEP=1 the slowest divider tap is only 128 cycles per phase, so four rate codes, including the slowest one, can each be timed exactly within a short run. The short debounce window makes it affordable to show both a rejected two-cycle glitch and an accepted long press. At the fastest code a full operation spans only eight cycles, so every operation code can be followed through all four phases while the inputs are disturbed mid-cycle.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_SET = 2'b01,
        OP_CLR = 2'b10,
        OP_ALL = 2'b11
    } sw_op_e;

    typedef struct packed {
        logic cs;
        logic strobe;
        logic data;
        logic clr;
    } mtx_ctl_t;

    localparam logic [1:0] PH_STROBE = 2'd1;
    localparam logic [1:0] PH_LAST   = 2'd3;

    // number of low divider bits that must be all ones for rate code k
    function automatic int tap_bits(input int code, input int step);
        return step * (7 - code) + 1;
    endfunction

endpackage

// File: rtl/swcmd_debounce.sv
module swcmd_debounce #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic press_tick
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic          sync1_q, sync2_q, level_q;
    logic [CW-1:0] cnt_q;
    logic          settle;

    assign settle = (sync2_q != level_q) && (cnt_q == CW'(DEB_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q    <= 1'b0;
            sync2_q    <= 1'b0;
            level_q    <= 1'b0;
            cnt_q      <= '0;
            press_tick <= 1'b0;
        end else begin
            sync1_q    <= btn;
            sync2_q    <= sync1_q;
            press_tick <= settle && sync2_q;
            if (sync2_q == level_q) begin
                cnt_q <= '0;
            end else if (settle) begin
                level_q <= sync2_q;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    AST_STEP_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        press_tick |=> !press_tick); // R9

endmodule

// File: rtl/swcmd_rate.sv
module swcmd_rate
    import swcmd_pkg::*;
#(
    parameter int STEP = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] rate_sel,
    input  logic       step_tick,
    output logic       tick
);
    localparam int DIV_W = 6 * STEP + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] tap_mask [1:7];

    for (genvar k = 1; k <= 7; k++) begin : g_tap
        assign tap_mask[k] = DIV_W'((64'd1 << tap_bits(k, STEP)) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + DIV_W'(1);
    end

    always_comb begin
        if (rate_sel == 3'd0) tick = step_tick;
        else                  tick = (div_q & tap_mask[rate_sel]) == tap_mask[rate_sel];
    end

    AST_FAST_SPACING: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 3'd7 && $past(rate_sel) == 3'd7 && tick) |=> !tick); // R8

endmodule

// File: rtl/swcmd_phase.sv
module swcmd_phase
    import swcmd_pkg::*;
#(
    parameter int ROW_AW = 4,
    parameter int COL_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  sw_op_e            op_in,
    input  logic [ROW_AW-1:0] row_in,
    input  logic [COL_AW-1:0] col_in,
    input  logic              ext_in,
    output logic [1:0]        phase,
    output sw_op_e            op_q,
    output logic [ROW_AW-1:0] row_q,
    output logic [COL_AW-1:0] col_q,
    output logic              ext_q
);
    logic wrap;
    assign wrap = tick && (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 2'd0;
            op_q  <= OP_NOP;
            row_q <= '0;
            col_q <= '0;
            ext_q <= 1'b0;
        end else begin
            if (tick) phase <= phase + 2'd1;
            if (wrap) begin
                op_q  <= op_in;
                row_q <= row_in;
                col_q <= col_in;
                ext_q <= ext_in;
            end
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase) |-> phase == 2'($past(phase) + 2'd1)); // R7
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0) |-> ($stable(row_q) && $stable(col_q) && $stable(op_q))); // R6
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0) |-> $stable(ext_q)); // R11

endmodule

// File: rtl/swcmd_phaser.sv
module swcmd_phaser
    import swcmd_pkg::*;
#(
    parameter int ROWS    = 16,
    parameter int COLS    = 16,
    parameter int STEP    = 2,
    parameter int DEB_CYC = 16,
    localparam int ROW_AW = $clog2(ROWS),
    localparam int COL_AW = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        rate_sel,
    input  logic              step_btn,
    input  logic [1:0]        op_code,
    input  logic [ROW_AW-1:0] row_addr,
    input  logic [COL_AW-1:0] col_addr,
    input  logic              use_ext,
    input  logic [COLS-1:0]   int_cols,
    input  logic [COLS-1:0]   ext_cols,
    output logic [1:0]        phase,
    output logic [ROW_AW-1:0] mtx_row,
    output logic [COL_AW-1:0] mtx_col,
    output logic              int_cs,
    output logic              int_strobe,
    output logic              int_data,
    output logic              int_clr,
    output logic              ext_cs,
    output logic              ext_strobe,
    output logic              ext_data,
    output logic              ext_clr,
    output logic [COLS-1:0]   col_out
);
    logic     step_tick, tick, ext_q;
    sw_op_e   op_q;
    mtx_ctl_t ctl;

    swcmd_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk(clk), .rst(rst), .btn(step_btn), .press_tick(step_tick)
    );

    swcmd_rate #(.STEP(STEP)) u_rate (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .step_tick(step_tick), .tick(tick)
    );

    swcmd_phase #(.ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_phase (
        .clk(clk), .rst(rst), .tick(tick), .op_in(sw_op_e'(op_code)),
        .row_in(row_addr), .col_in(col_addr), .ext_in(use_ext),
        .phase(phase), .op_q(op_q), .row_q(mtx_row), .col_q(mtx_col), .ext_q(ext_q)
    );

    always_comb begin
        ctl      = '0;
        ctl.data = (op_q == OP_SET);
        if (phase == PH_STROBE) begin
            unique case (op_q)
                OP_SET, OP_CLR: begin ctl.cs = 1'b1; ctl.strobe = 1'b1; end
                OP_ALL:         ctl.clr = 1'b1;
                default:        ;
            endcase
        end
    end

    assign {int_cs, int_strobe, int_data, int_clr} = ctl;
    assign {ext_cs, ext_strobe, ext_data, ext_clr} = ctl;
    assign col_out = ext_q ? ext_cols : int_cols;

    AST_CTL_PHASE1: assert property (@(posedge clk) disable iff (rst)
        (int_cs || int_strobe || int_clr || ext_cs || ext_strobe || ext_clr) |-> phase == 2'd1); // R5
    AST_CS_NOT_CLR: assert property (@(posedge clk) disable iff (rst)
        !(int_cs && int_clr)); // R3
    AST_CS_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        int_cs == int_strobe); // R1

endmodule

// File: tb/swcmd_phaser_bench.sv
module swcmd_phaser_bench;
    localparam int COLS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rate_sel = 3'd7;
    logic        step_btn = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [3:0]  row_addr = '0, col_addr = '0;
    logic        use_ext = 1'b0;
    logic [COLS-1:0] int_cols = 16'hA5A5, ext_cols = 16'h3C3C;
    logic [1:0]  phase;
    logic [3:0]  mtx_row, mtx_col;
    logic        int_cs, int_strobe, int_data, int_clr;
    logic        ext_cs, ext_strobe, ext_data, ext_clr;
    logic [COLS-1:0] col_out;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    swcmd_phaser #(.ROWS(16), .COLS(COLS), .STEP(1), .DEB_CYC(4)) u_swcmd_phaser (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .step_btn(step_btn),
        .op_code(op_code), .row_addr(row_addr), .col_addr(col_addr), .use_ext(use_ext),
        .int_cols(int_cols), .ext_cols(ext_cols), .phase(phase),
        .mtx_row(mtx_row), .mtx_col(mtx_col),
        .int_cs(int_cs), .int_strobe(int_strobe), .int_data(int_data), .int_clr(int_clr),
        .ext_cs(ext_cs), .ext_strobe(ext_strobe), .ext_data(ext_data), .ext_clr(ext_clr),
        .col_out(col_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // R5 monitor: strobes never outside phase 1
    always @(negedge clk) begin
        if (!rst && !done && (int_cs || int_strobe || int_clr || ext_cs || ext_strobe || ext_clr)
            && phase != 2'd1)
            check(1'b0, "R5 strobe outside phase 1", phase, 1);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            check(1'b0, "watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic t_reset();
        check(phase == 2'd0, "R12 phase", phase, 0);
        check({int_cs, int_strobe, int_data, int_clr, ext_cs, ext_strobe, ext_data, ext_clr} == 8'd0,
              "R12 controls", {int_cs, int_strobe, int_data, int_clr}, 0);
        check(col_out == int_cols, "R12 internal selected", col_out, int_cols);
    endtask

    task automatic wait_wrap();
        while (phase != 2'd3) @(negedge clk);
        while (phase != 2'd0) @(negedge clk);
    endtask

    task automatic t_op(input logic [1:0] op, input logic [3:0] r, input logic [3:0] c,
                        input bit ext, input string req);
        bit saw1 = 0;
        @(negedge clk);
        rate_sel = 3'd7; op_code = op; row_addr = r; col_addr = c; use_ext = ext;
        wait_wrap();
        op_code = ~op; row_addr = ~r; col_addr = ~c;   // R6 disturb inputs
        for (int i = 0; i < 7; i++) begin
            logic [3:0] expc;
            @(negedge clk);
            expc[3] = (phase == 2'd1) && (op == 2'b01 || op == 2'b10);
            expc[2] = expc[3];
            expc[1] = (op == 2'b01);
            expc[0] = (phase == 2'd1) && (op == 2'b11);
            if (phase == 2'd1) saw1 = 1;
            check({int_cs, int_strobe, int_data, int_clr} == expc, req,
                  {int_cs, int_strobe, int_data, int_clr}, expc);
            check({ext_cs, ext_strobe, ext_data, ext_clr} == expc, "R10 broadcast",
                  {ext_cs, ext_strobe, ext_data, ext_clr}, expc);
            check(mtx_row == r && mtx_col == c, "R6 address hold", {mtx_row, mtx_col}, {r, c});
        end
        check(saw1, "R7 phase 1 reached", saw1, 1);
    endtask

    task automatic t_rate(input logic [2:0] code);
        logic [1:0] p0;
        int n = 0;
        @(negedge clk);
        rate_sel = code;
        p0 = phase;
        while (phase == p0) @(negedge clk);
        p0 = phase;
        while (phase == p0) begin @(negedge clk); n++; end
        check(n == (1 << (8 - code)), "R8 tick period", n, 1 << (8 - code));
        check(phase == 2'(p0 + 2'd1), "R7 phase increment", phase, 2'(p0 + 2'd1));
    endtask

    task automatic t_step();
        logic [1:0] p0;
        @(negedge clk);
        rate_sel = 3'd0;
        repeat (20) @(negedge clk);
        p0 = phase;
        step_btn = 1'b1; repeat (2) @(negedge clk); step_btn = 1'b0;
        repeat (20) @(negedge clk);
        check(phase == p0, "R9 glitch ignored", phase, p0);
        step_btn = 1'b1; repeat (40) @(negedge clk);
        check(phase == 2'(p0 + 2'd1), "R9 one step while held", phase, 2'(p0 + 2'd1));
        step_btn = 1'b0; repeat (20) @(negedge clk);
        check(phase == 2'(p0 + 2'd1), "R9 release no step", phase, 2'(p0 + 2'd1));
        step_btn = 1'b1; repeat (15) @(negedge clk); step_btn = 1'b0;
        repeat (15) @(negedge clk);
        check(phase == 2'(p0 + 2'd2), "R9 second press", phase, 2'(p0 + 2'd2));
    endtask

    task automatic t_select();
        @(negedge clk);
        rate_sel = 3'd7; use_ext = 1'b0;
        wait_wrap();
        while (phase != 2'd2) @(negedge clk);
        use_ext = 1'b1;
        @(negedge clk);
        check(col_out == int_cols, "R11 select held mid-cycle", col_out, int_cols);
        while (phase != 2'd0) @(negedge clk);
        check(col_out == ext_cols, "R11 external after wrap", col_out, ext_cols);
        ext_cols = 16'h0FF0; @(negedge clk);
        check(col_out == 16'h0FF0, "R11 follows external", col_out, 16'h0FF0);
        use_ext = 1'b0;
        wait_wrap();
        check(col_out == int_cols, "R11 back to internal", col_out, int_cols);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_op(2'b01, 4'd5, 4'd9, 1'b0, "R1 set pattern");
        t_op(2'b10, 4'd15, 4'd0, 1'b0, "R2 clear pattern");
        t_op(2'b11, 4'd3, 4'd12, 1'b1, "R3 clear-all pattern");
        t_op(2'b00, 4'd7, 4'd7, 1'b1, "R4 nop pattern");
        t_op(2'b01, 4'd0, 4'd15, 1'b1, "R1 set to external selection");
        t_rate(3'd7);
        t_rate(3'd5);
        t_rate(3'd3);
        t_rate(3'd1);
        t_select();
        t_step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule